// File: doc/BRIEF.md
# Rotated Constellation Cell Processor

This block sits between a constellation mapper and a cell interleaver in a broadcast transmit chain. It takes complex cells as signed fixed-point I/Q pairs, one FEC block at a time. Each cell is rotated in the complex plane by an angle that depends on the modulation order. The imaginary part of each rotated cell is then moved one cell later, and the move wraps around inside the FEC block. The four rotation coefficients are a programmable table on ports, so the block fixes no angle values of its own.

A cell carrying the start flag opens a block. On that cell the block samples the modulation code, the short/long code selector and the rotation enable, and keeps them for the rest of the block. It counts cells against the block length in cells, which follows from the FEC length and the bits per cell. The imaginary part of the last cell belongs to the first cell of the block. The block therefore keeps only the real part of cell 0 and emits cell 0 as the closing beat of the block, after cells 1 to N-1. This avoids storing the whole block. With rotation disabled, cells pass straight through in arrival order.

Top module: `rotcell_proc`

## Requirements
- R1: While reset is active, and in the first cycle after it, out_valid_o and err_o are low. After reset, in_ready_o is high.
- R2: With rotation enabled, re' = re·c − im·s and im' = re·s + im·c. Here c and s are the coefficients in slice mod·CW of the cosine and sine table ports, with 1.0 = 2^(CW-2). Each sum has 2^(CW-3) added, is shifted arithmetically right by CW-2, and is saturated to the signed DW-bit range.
- R3: With rotation enabled, accepting cell k (k ≥ 1) of a block produces one output beat carrying re'(k) and im'(k−1). The beat is presented in the cycle after acceptance. The beat of cell 1 carries out_sob_o.
- R4: With rotation enabled, cell 0 produces no beat when it arrives. After the beat of cell N−1, one closing beat carries re'(0) and im'(N−1) with out_eob_o set. No beat has both sob and eob.
- R5: N = L / (2·(mod+1)). L is 16200 when long_i is 0 and 64800 when it is 1. The mod codes are 0 = QPSK, 1 = 16-QAM, 2 = 64-QAM and 3 = 256-QAM.
- R6: With rotation disabled, each cell is emitted unchanged as one beat, in order. out_sob_o is set on cell 0 and out_eob_o on cell N−1.
- R7: mod_i, long_i and rot_en_i are sampled only on the cell that carries in_sob_i. Their values on other cells have no effect on the output.
- R8: No beat is dropped, duplicated or reordered under back-pressure. While out_valid_o is high and out_ready_i is low, the output beat holds still and in_ready_o is low. in_ready_o is also low while a closing beat waits.
- R9: A start cell accepted before the open block reached N cells raises err_o for one cycle after that acceptance. That start cell opens a new block, and the aborted block's closing beat is never emitted.
- R10: A cell without the start flag, accepted while no block is open, is dropped and raises err_o for one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input cell valid |
| in_ready_o | output | 1 | Input cell accepted when high with valid |
| in_sob_i | input | 1 | Cell is the first of a FEC block |
| in_re_i | input | DW | Real part, signed |
| in_im_i | input | DW | Imaginary part, signed |
| mod_i | input | 2 | Modulation code, sampled with start |
| long_i | input | 1 | 1 = long FEC block, sampled with start |
| rot_en_i | input | 1 | Rotation and delay enable, sampled with start |
| coef_cos_i | input | 4·CW | Cosine coefficient per modulation code |
| coef_sin_i | input | 4·CW | Sine coefficient per modulation code |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Downstream ready |
| out_re_o | output | DW | Output real part |
| out_im_o | output | DW | Output imaginary part |
| out_sob_o | output | 1 | First beat of the block |
| out_eob_o | output | 1 | Last beat of the block |
| err_o | output | 1 | One-cycle pulse on a framing error |

## Verification
The assertions take for granted that the coefficient table stays constant while a block is in flight. They also assume that reset is applied before the first cell. They make no assumption about how out_ready_i behaves. Input valid is not required to be held, but the stimulus holds each presented cell until it is accepted. It changes the table only while no block is open, which in practice means never, and it toggles out_ready_i randomly. The mod_i, long_i and rot_en_i values are randomised on cells that do not carry the start flag.

// File: rtl/rotcell_pkg.sv
package rotcell_pkg;

  typedef enum logic [1:0] {
    MOD_QPSK   = 2'd0,
    MOD_QAM16  = 2'd1,
    MOD_QAM64  = 2'd2,
    MOD_QAM256 = 2'd3
  } mod_e;

  // Cells in one FEC block: bits per block over bits per cell.
  function automatic int unsigned cells_in_block(input int unsigned bits,
                                                 input int unsigned mod_code);
    return bits / (2 * (mod_code + 1));
  endfunction

endpackage

// File: rtl/rotcell_rotator.sv
module rotcell_rotator #(
  parameter int DW = 12,
  parameter int CW = 12
) (
  input  logic signed [DW-1:0] re_i,
  input  logic signed [DW-1:0] im_i,
  input  logic signed [CW-1:0] cos_i,
  input  logic signed [CW-1:0] sin_i,
  output logic signed [DW-1:0] re_o,
  output logic signed [DW-1:0] im_o
);
  localparam int PW = DW + CW + 1;
  localparam int FR = CW - 2;
  localparam logic signed [PW-1:0] HALF = PW'(longint'(1) << (FR - 1));
  localparam logic signed [PW-1:0] MAXV = PW'((longint'(1) << (DW - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

  logic signed [PW-1:0] re_x, im_x, c_x, s_x;
  logic signed [PW-1:0] sum  [2];
  logic signed [DW-1:0] lane [2];

  assign re_x = PW'(re_i);
  assign im_x = PW'(im_i);
  assign c_x  = PW'(cos_i);
  assign s_x  = PW'(sin_i);

  assign sum[0] = re_x * c_x - im_x * s_x;
  assign sum[1] = re_x * s_x + im_x * c_x;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic signed [PW-1:0] shifted;
    assign shifted = (sum[g] + HALF) >>> FR;
    assign lane[g] = (shifted > MAXV) ? MAXV[DW-1:0] :
                     (shifted < MINV) ? MINV[DW-1:0] : shifted[DW-1:0];
  end

  assign re_o = lane[0];
  assign im_o = lane[1];
endmodule

// File: rtl/rotcell_blkctl.sv
module rotcell_blkctl
  import rotcell_pkg::*;
#(
  parameter int SHORT_BITS = 16200,
  parameter int LONG_BITS  = 64800,
  parameter int CNT_W      = $clog2(LONG_BITS / 2 + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             sob_i,
  input  logic [1:0]       mod_i,
  input  logic             long_i,
  input  logic             en_i,
  output mod_e             cur_mod_o,
  output logic             cur_en_o,
  output logic [CNT_W-1:0] cur_idx_o,
  output logic             cur_last_o,
  output logic             cur_drop_o,
  output logic             err_o
);
  localparam int NLEN = 8;

  logic [CNT_W-1:0] len_tab [NLEN];
  for (genvar g = 0; g < NLEN; g++) begin : g_len
    localparam int BITS = (g >= 4) ? LONG_BITS : SHORT_BITS;
    assign len_tab[g] = CNT_W'(cells_in_block(BITS, g % 4));
  end

  logic             open_q, open_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  mod_e             mod_q;
  logic             long_q, en_q, err_q, err_d;
  logic             cnt_en, cfg_en, cur_long;
  logic [CNT_W-1:0] cur_len;

  always_comb begin
    cur_mod_o  = sob_i ? mod_e'(mod_i) : mod_q;
    cur_long   = sob_i ? long_i : long_q;
    cur_en_o   = sob_i ? en_i : en_q;
    cur_len    = len_tab[{cur_long, cur_mod_o}];
    cur_idx_o  = sob_i ? '0 : cnt_q;
    cur_drop_o = !sob_i && !open_q;
    cur_last_o = !cur_drop_o && (cur_idx_o == cur_len - 1'b1);
    cnt_en     = acc_i && !cur_drop_o;
    cnt_d      = cur_idx_o + 1'b1;
    open_d     = !cur_last_o;
    cfg_en     = acc_i && sob_i;
    err_d      = acc_i && (sob_i ? open_q : !open_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
      mod_q  <= MOD_QPSK;
      long_q <= 1'b0;
      en_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= err_d;
      if (cnt_en) begin
        open_q <= open_d;
        cnt_q  <= cnt_d;
      end
      if (cfg_en) begin
        mod_q  <= mod_e'(mod_i);
        long_q <= long_i;
        en_q   <= en_i;
      end
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/rotcell_proc.sv
module rotcell_proc
  import rotcell_pkg::*;
#(
  parameter int DW         = 12,
  parameter int CW         = 12,
  parameter int SHORT_BITS = 16200,
  parameter int LONG_BITS  = 64800
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic            in_sob_i,
  input  logic [DW-1:0]   in_re_i,
  input  logic [DW-1:0]   in_im_i,
  input  logic [1:0]      mod_i,
  input  logic            long_i,
  input  logic            rot_en_i,
  input  logic [4*CW-1:0] coef_cos_i,
  input  logic [4*CW-1:0] coef_sin_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [DW-1:0]   out_re_o,
  output logic [DW-1:0]   out_im_o,
  output logic            out_sob_o,
  output logic            out_eob_o,
  output logic            err_o
);
  localparam int CNT_W = $clog2(LONG_BITS / 2 + 1);

  mod_e             cur_mod;
  logic             cur_en, cur_last, cur_drop, acc, out_free;
  logic [CNT_W-1:0] cur_idx;
  logic signed [CW-1:0] cos_sel, sin_sel;
  logic signed [DW-1:0] rot_re, rot_im;

  rotcell_blkctl #(
    .SHORT_BITS(SHORT_BITS),
    .LONG_BITS (LONG_BITS),
    .CNT_W     (CNT_W)
  ) u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (acc),
    .sob_i     (in_sob_i),
    .mod_i     (mod_i),
    .long_i    (long_i),
    .en_i      (rot_en_i),
    .cur_mod_o (cur_mod),
    .cur_en_o  (cur_en),
    .cur_idx_o (cur_idx),
    .cur_last_o(cur_last),
    .cur_drop_o(cur_drop),
    .err_o     (err_o)
  );

  assign cos_sel = coef_cos_i[int'(cur_mod)*CW +: CW];
  assign sin_sel = coef_sin_i[int'(cur_mod)*CW +: CW];

  rotcell_rotator #(.DW(DW), .CW(CW)) u_rot (
    .re_i (in_re_i),
    .im_i (in_im_i),
    .cos_i(cos_sel),
    .sin_i(sin_sel),
    .re_o (rot_re),
    .im_o (rot_im)
  );

  // Output stage and closing-beat slot
  logic          ov_q, ov_d, osob_q, osob_d, oeob_q, oeob_d;
  logic [DW-1:0] ore_q, ore_d, oim_q, oim_d;
  logic          cl_q, cl_d;
  logic [DW-1:0] cl_re_q, cl_re_d, cl_im_q, cl_im_d;
  logic [DW-1:0] first_re_q, prev_im_q;
  logic          first_en, prev_en;

  assign out_free   = !ov_q || out_ready_i;
  assign in_ready_o = out_free && !cl_q;
  assign acc        = in_valid_i && in_ready_o;

  always_comb begin
    ov_d     = 1'b0;
    ore_d    = ore_q;
    oim_d    = oim_q;
    osob_d   = 1'b0;
    oeob_d   = 1'b0;
    cl_d     = cl_q;
    cl_re_d  = cl_re_q;
    cl_im_d  = cl_im_q;
    first_en = 1'b0;
    prev_en  = 1'b0;
    if (cl_q) begin
      ov_d   = 1'b1;
      ore_d  = cl_re_q;
      oim_d  = cl_im_q;
      oeob_d = 1'b1;
      cl_d   = 1'b0;
    end else if (acc && !cur_drop) begin
      if (!cur_en) begin
        ov_d   = 1'b1;
        ore_d  = in_re_i;
        oim_d  = in_im_i;
        osob_d = (cur_idx == '0);
        oeob_d = cur_last;
      end else begin
        prev_en = 1'b1;
        if (cur_idx == '0) begin
          first_en = 1'b1;
        end else begin
          ov_d   = 1'b1;
          ore_d  = rot_re;
          oim_d  = prev_im_q;
          osob_d = (cur_idx == CNT_W'(1));
          if (cur_last) begin
            cl_d    = 1'b1;
            cl_re_d = first_re_q;
            cl_im_d = rot_im;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ov_q       <= 1'b0;
      ore_q      <= '0;
      oim_q      <= '0;
      osob_q     <= 1'b0;
      oeob_q     <= 1'b0;
      cl_q       <= 1'b0;
      cl_re_q    <= '0;
      cl_im_q    <= '0;
      first_re_q <= '0;
      prev_im_q  <= '0;
    end else begin
      if (out_free) begin
        ov_q    <= ov_d;
        ore_q   <= ore_d;
        oim_q   <= oim_d;
        osob_q  <= osob_d;
        oeob_q  <= oeob_d;
        cl_q    <= cl_d;
        cl_re_q <= cl_re_d;
        cl_im_q <= cl_im_d;
      end
      if (first_en) first_re_q <= rot_re;
      if (prev_en)  prev_im_q  <= rot_im;
    end
  end

  assign out_valid_o = ov_q;
  assign out_re_o    = ore_q;
  assign out_im_o    = oim_q;
  assign out_sob_o   = osob_q;
  assign out_eob_o   = oeob_q;
endmodule

// File: rtl/rotcell_checker.sv
module rotcell_checker #(
  parameter int DW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic [DW-1:0] out_re_o,
  input logic [DW-1:0] out_im_o,
  input logic          out_sob_o,
  input logic          out_eob_o,
  input logic          err_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!out_valid_o && !err_o);
    end
  end

  p_hold_beat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_re_o) &&
      $stable(out_im_o) && $stable(out_sob_o) && $stable(out_eob_o));

  p_backpressure_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  // Covers R10 as well: every error follows an accepted cell.
  p_err_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(in_valid_i && in_ready_o));

  p_marks_apart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !(out_sob_o && out_eob_o));
endmodule

bind rotcell_proc rotcell_checker #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_re_o   (out_re_o),
  .out_im_o   (out_im_o),
  .out_sob_o  (out_sob_o),
  .out_eob_o  (out_eob_o),
  .err_o      (err_o)
);

// File: tb/rotcell_proc_tb_top.sv
`timescale 1ns/1ps
module rotcell_proc_tb_top;
  localparam int DW = 12;
  localparam int CW = 12;

  typedef struct packed {
    logic          sob;
    logic [1:0]    md;
    logic          lng;
    logic          en;
    logic [DW-1:0] re;
    logic [DW-1:0] im;
  } cell_t;

  typedef struct packed {
    logic [DW-1:0] re;
    logic [DW-1:0] im;
    logic          sob;
    logic          eob;
  } beat_t;

  logic clk = 1'b0;
  logic rst_ni;
  logic in_valid, in_ready, in_sob, lng, rot_en;
  logic [DW-1:0] in_re, in_im, out_re, out_im;
  logic [1:0] md;
  logic [4*CW-1:0] coef_cos, coef_sin;
  logic out_valid, out_ready, out_sob, out_eob, err;

  always #2.5 clk = ~clk;

  rotcell_proc dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_sob_i(in_sob),
    .in_re_i(in_re), .in_im_i(in_im), .mod_i(md), .long_i(lng),
    .rot_en_i(rot_en), .coef_cos_i(coef_cos), .coef_sin_i(coef_sin),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_re_o(out_re), .out_im_o(out_im), .out_sob_o(out_sob),
    .out_eob_o(out_eob), .err_o(err)
  );

  int cos_t [4] = '{896, 980, 1012, 1022};
  int sin_t [4] = '{496, 296, 152, 64};

  int n_chk = 0;
  int n_bad = 0;
  string tag = "R1";

  cell_t src_q [$];
  beat_t exp_q [$];

  // reference model state
  bit m_open = 0;
  int m_idx, m_n, m_mod;
  bit m_en;
  int m_first_re, m_prev_im;
  bit err_pend = 0;

  bit presenting = 0, stall_on = 0, gap_on = 0;
  bit held_valid = 0;
  beat_t held_beat;

  task automatic check(input string t, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", t, act, expv);
    end
  endtask

  function automatic int rsat(input int p);
    int q;
    q = (p + 512) >>> 10;
    if (q > 2047) q = 2047;
    if (q < -2048) q = -2048;
    return q;
  endfunction

  function automatic void model_accept(input cell_t c);
    int re, im, rr, ri;
    bit e;
    e = 0;
    if (c.sob) begin
      if (m_open) e = 1;
      m_open = 1;
      m_idx  = 0;
      m_mod  = int'(c.md);
      m_en   = c.en;
      m_n    = (c.lng ? 64800 : 16200) / (2 * (m_mod + 1));
    end else if (!m_open) begin
      err_pend = 1;
      return;
    end
    err_pend = e;
    re = $signed(c.re);
    im = $signed(c.im);
    rr = rsat(re * cos_t[m_mod] - im * sin_t[m_mod]);
    ri = rsat(re * sin_t[m_mod] + im * cos_t[m_mod]);
    if (!m_en) begin
      exp_q.push_back('{re: c.re, im: c.im, sob: (m_idx == 0), eob: (m_idx == m_n - 1)});
    end else if (m_idx == 0) begin
      m_first_re = rr;
      m_prev_im  = ri;
    end else begin
      exp_q.push_back('{re: DW'(rr), im: DW'(m_prev_im), sob: (m_idx == 1), eob: 1'b0});
      m_prev_im = ri;
      if (m_idx == m_n - 1)
        exp_q.push_back('{re: DW'(m_first_re), im: DW'(ri), sob: 1'b0, eob: 1'b1});
    end
    m_idx++;
    if (m_idx == m_n) m_open = 0;
  endfunction

  task automatic step();
    beat_t e;
    @(negedge clk);
    check("R9 R10 error pulse", int'(err), int'(err_pend));
    err_pend = 0;
    if (held_valid) begin
      check("R8 stalled valid", int'(out_valid), 1);
      check("R8 stalled beat", int'({out_re, out_im, out_sob, out_eob}), int'(held_beat));
    end
    out_ready = stall_on ? ($urandom_range(3) != 0) : 1'b1;
    if (!presenting && src_q.size() > 0 && (!gap_on || $urandom_range(2) != 0))
      presenting = 1;
    in_valid = presenting;
    if (presenting) begin
      in_sob = src_q[0].sob; md = src_q[0].md; lng = src_q[0].lng;
      rot_en = src_q[0].en; in_re = src_q[0].re; in_im = src_q[0].im;
    end
    #1;
    held_valid = out_valid && !out_ready;
    held_beat  = '{re: out_re, im: out_im, sob: out_sob, eob: out_eob};
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check({tag, " R8 unexpected beat"}, 1, 0);
      end else begin
        e = exp_q.pop_front();
        check({tag, " re"}, int'($signed(out_re)), int'($signed(e.re)));
        check({tag, " im"}, int'($signed(out_im)), int'($signed(e.im)));
        check({tag, " sob"}, int'(out_sob), int'(e.sob));
        check({tag, " eob"}, int'(out_eob), int'(e.eob));
      end
    end
    if (in_valid && in_ready) begin
      model_accept(src_q.pop_front());
      presenting = 0;
    end
  endtask

  // Non-start cells get random configuration values to show R7.
  task automatic gen_block(input int mcode, input bit lcode, input bit en, input int count);
    cell_t c;
    for (int i = 0; i < count; i++) begin
      c.sob = (i == 0);
      c.md  = (i == 0) ? 2'(mcode) : 2'($urandom_range(3));
      c.lng = (i == 0) ? lcode : 1'($urandom_range(1));
      c.en  = (i == 0) ? en : 1'($urandom_range(1));
      c.re  = DW'($urandom);
      c.im  = DW'($urandom);
      src_q.push_back(c);
    end
  endtask

  task automatic gen_stray();
    cell_t c;
    c = '0;
    c.re = DW'($urandom);
    c.im = DW'($urandom);
    src_q.push_back(c);
  endtask

  task automatic run(input bit st, input bit gp);
    stall_on = st;
    gap_on   = gp;
    while (src_q.size() > 0 || exp_q.size() > 0 || presenting) step();
    step();
    step();
    check({tag, " R8 all beats delivered"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int m = 0; m < 4; m++) begin
      coef_cos[m*CW +: CW] = CW'(cos_t[m]);
      coef_sin[m*CW +: CW] = CW'(sin_t[m]);
    end
    rst_ni = 1'b0; in_valid = 0; in_sob = 0; md = 0; lng = 0; rot_en = 0;
    in_re = '0; in_im = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(out_valid), 0);
    check("R1 err in reset", int'(err), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(in_ready), 1);
    check("R1 valid after reset", int'(out_valid), 0);

    tag = "R2 R3 R4 R5 256QAM short";
    gen_block(3, 0, 1, 2025); run(0, 0);
    tag = "R8 R3 64QAM short stalled";
    gen_block(2, 0, 1, 2700); run(1, 1);
    tag = "R6 bypass 16QAM";
    gen_block(1, 0, 0, 4050); run(1, 0);
    tag = "R2 R4 R7 QPSK short";
    gen_block(0, 0, 1, 8100); run(0, 1);
    tag = "R5 256QAM long";
    gen_block(3, 1, 1, 8100); run(1, 1);
    tag = "R9 abort rotated";
    gen_block(3, 0, 1, 100); gen_block(2, 0, 1, 2700); run(1, 1);
    tag = "R9 abort bypass";
    gen_block(1, 0, 0, 50); gen_block(3, 0, 0, 2025); run(0, 1);
    tag = "R10 stray cell";
    gen_stray(); gen_block(3, 0, 1, 2025); gen_stray(); run(1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule